// File: doc/BRIEF.md
# Blocking Rendezvous Link Port

This block sits between one processor node of a mesh and its four neighbours. It carries single 18-bit words across the node's links, with no storage. A read stalls the node until a selected neighbour offers a word. A write stalls the node until every selected neighbour has taken the word. A transfer happens in the same cycle in which both partners request it, and both partners are released in that cycle. The word only passes through combinational paths; it is never held in a register.

The node picks its links with a 4-bit mask. On a write, setting several mask bits copies one word to several neighbours. On a read, setting several mask bits takes the first neighbour that is ready. A third access kind, fetch, works like a read but sends the word to the node's instruction sequencer. This lets a neighbour push code straight into the node. If both ends of one link write it at the same time, or both ends read it at the same time, neither end can finish. The block reports this on a flag.

The controller is a small state machine with four states:
- ST_IDLE: no access is waiting.
- ST_READ_WAIT: a stalled read is waiting.
- ST_WRITE_WAIT: a stalled write is waiting.
- ST_FETCH_WAIT: a stalled fetch is waiting.

From ST_IDLE, an access that does not finish in its first cycle moves to the matching wait state. A wait state returns to ST_IDLE in the cycle the access finishes. It also returns there if the node drops or changes the access.

While a write waits, a register records which links have already taken the word.

Top module: `nlink_port`

## Requirements
- R1: Access codes on `op_i` are 0 none, 1 read, 2 write and 3 fetch. Mask bits on `mask_i` are bit 0 north, bit 1 east, bit 2 south and bit 3 west. A read asserts `link_rd_req_o` on its masked links and keeps `stall_o` high until a masked neighbour raises `nb_wr_req_i`. In that same cycle `stall_o` is low, `rd_valid_o` is high, `rdata_o` equals that neighbour's word, and the matching `link_take_o` bit is high.
- R2: A write offers `wdata_i` on `link_wdata_o` and raises `link_wr_req_o` on its masked links. `stall_o` stays high until the neighbours read. Each link completes, with its `link_give_o` bit high, in the cycle its `nb_rd_req_i` bit is high.
- R3: A multi-link write completes only when every masked link has taken the word, in one cycle or spread over several. A link that has already taken the word drops its `link_wr_req_o` bit and is not given the word again during that access.
- R4: When a read or fetch finds writers waiting on several masked links, it takes only the lowest-numbered one (north first, then east, south, west). Exactly that one `link_take_o` bit is high.
- R5: A fetch delivers the word on `ins_word_o` with `ins_valid_o` high. `rd_valid_o` stays low and `rdata_o` stays zero.
- R6: `deadlock_o` is high in any cycle in which a link carries a write request from both ends or a read request from both ends. A write blocked this way does not complete and keeps the node stalled.
- R7: After reset with no access requested, `stall_o`, `deadlock_o`, all valid outputs and all link request, take and give outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Access kind: 0 none, 1 read, 2 write, 3 fetch |
| mask_i | input | 4 | Link select, bit 0 N, 1 E, 2 S, 3 W |
| wdata_i | input | 18 | Word to write |
| stall_o | output | 1 | Node must hold its access |
| rdata_o | output | 18 | Word read for the data stack |
| rd_valid_o | output | 1 | Read completed this cycle |
| ins_word_o | output | 18 | Word fetched for the sequencer |
| ins_valid_o | output | 1 | Fetch completed this cycle |
| link_rd_req_o | output | 4 | Node is reading this link |
| link_wr_req_o | output | 4 | Node still offers a word on this link |
| link_wdata_o | output | 18 | Word offered to neighbours |
| link_take_o | output | 4 | Neighbour's write accepted this cycle |
| link_give_o | output | 4 | Neighbour's read served this cycle |
| nb_rd_req_i | input | 4 | Neighbour is reading this link |
| nb_wr_req_i | input | 4 | Neighbour is writing this link |
| nb_wdata_i | input | 72 | Neighbour words, link k in bits 18k+17:18k |
| deadlock_o | output | 1 | Both ends of some link request the same direction |

## Verification
The assertions assume three things about the inputs:
- The node holds `op_i`, `mask_i` and `wdata_i` stable while `stall_o` is high.
- A read or fetch always has a non-zero mask.
- A neighbour never asserts both its read and its write request on the same link at once.

The stimulus respects all three. It picks a new access only after the previous one has finished, never draws a zero mask, and for each link draws one neighbour intention out of idle, read or write. Directed phases add conflicting writes, all four writers present at once, and a write to three links served one by one.

// File: rtl/nlink_pkg.sv
package nlink_pkg;
    localparam int NPORT  = 4;
    localparam int WORD_W = 18;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_FETCH = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_READ_WAIT  = 2'd1,
        ST_WRITE_WAIT = 2'd2,
        ST_FETCH_WAIT = 2'd3
    } state_e;
endpackage

// File: rtl/nlink_prio_pick.sv
module nlink_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] lower;

    assign lower[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            assign lower[i+1] = lower[i] | req[i];
            assign grant[i]   = req[i] & ~lower[i];
        end
    endgenerate
endmodule

// File: rtl/nlink_conflict.sv
module nlink_conflict #(
    parameter int N = 4
) (
    input  logic [N-1:0] my_wr,
    input  logic [N-1:0] my_rd,
    input  logic [N-1:0] nb_wr,
    input  logic [N-1:0] nb_rd,
    output logic         clash
);
    logic [N-1:0] per_link;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_link
            assign per_link[i] = (my_wr[i] & nb_wr[i]) | (my_rd[i] & nb_rd[i]);
        end
    endgenerate

    assign clash = |per_link;
endmodule

// File: rtl/nlink_ctrl.sv
module nlink_ctrl
    import nlink_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] nb_rd,
    input  logic [N-1:0] rd_grant,
    output logic [N-1:0] wr_left,
    output logic [N-1:0] give,
    output logic [N-1:0] rd_req,
    output logic         done,
    output logic         stall,
    output logic         is_fetch
);
    state_e       state_q, state_d;
    logic [N-1:0] served_q, served_d;
    logic [N-1:0] served_eff;
    op_e          op_k;

    assign op_k = op_e'(op);

    // state and served-link register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            served_q <= '0;
        end else begin
            state_q  <= state_d;
            served_q <= served_d;
        end
    end

    // outputs and next state
    always_comb begin
        served_eff = (state_q == ST_WRITE_WAIT) ? served_q : '0;
        wr_left    = '0;
        give       = '0;
        rd_req     = '0;
        done       = 1'b0;
        is_fetch   = 1'b0;
        unique case (op_k)
            OP_NONE: begin
                done = 1'b0;
            end
            OP_READ: begin
                rd_req = mask;
                done   = |rd_grant;
            end
            OP_WRITE: begin
                wr_left = mask & ~served_eff;
                give    = wr_left & nb_rd;
                done    = ((wr_left & ~give) == '0);
            end
            OP_FETCH: begin
                rd_req   = mask;
                done     = |rd_grant;
                is_fetch = 1'b1;
            end
        endcase
        stall = (op_k != OP_NONE) && !done;

        state_d  = state_q;
        served_d = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (stall) begin
                    unique case (op_k)
                        OP_READ:  state_d = ST_READ_WAIT;
                        OP_WRITE: state_d = ST_WRITE_WAIT;
                        OP_FETCH: state_d = ST_FETCH_WAIT;
                        OP_NONE:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_READ_WAIT: begin
                if (!stall || op_k != OP_READ) state_d = ST_IDLE;
            end
            ST_WRITE_WAIT: begin
                if (!stall || op_k != OP_WRITE) state_d = ST_IDLE;
            end
            ST_FETCH_WAIT: begin
                if (!stall || op_k != OP_FETCH) state_d = ST_IDLE;
            end
        endcase
        if (op_k == OP_WRITE && stall) served_d = served_eff | give;
    end
endmodule

// File: rtl/nlink_port.sv
module nlink_port
    import nlink_pkg::*;
#(
    parameter int NP = NPORT,
    parameter int W  = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      op_i,
    input  logic [NP-1:0]   mask_i,
    input  logic [W-1:0]    wdata_i,
    output logic            stall_o,
    output logic [W-1:0]    rdata_o,
    output logic            rd_valid_o,
    output logic [W-1:0]    ins_word_o,
    output logic            ins_valid_o,
    output logic [NP-1:0]   link_rd_req_o,
    output logic [NP-1:0]   link_wr_req_o,
    output logic [W-1:0]    link_wdata_o,
    output logic [NP-1:0]   link_take_o,
    output logic [NP-1:0]   link_give_o,
    input  logic [NP-1:0]   nb_rd_req_i,
    input  logic [NP-1:0]   nb_wr_req_i,
    input  logic [NP*W-1:0] nb_wdata_i,
    output logic            deadlock_o
);
    localparam int SELW = W;

    logic [NP-1:0]   rd_req, wr_left, give, grant, cand;
    logic            done, stall, is_fetch, readish;
    logic [SELW-1:0] word;

    assign readish = (op_i == OP_READ) || (op_i == OP_FETCH);
    assign cand    = readish ? (mask_i & nb_wr_req_i) : '0;

    nlink_prio_pick #(.N(NP)) pick_i (
        .req   (cand),
        .grant (grant)
    );

    nlink_ctrl #(.N(NP)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_i),
        .mask     (mask_i),
        .nb_rd    (nb_rd_req_i),
        .rd_grant (grant),
        .wr_left  (wr_left),
        .give     (give),
        .rd_req   (rd_req),
        .done     (done),
        .stall    (stall),
        .is_fetch (is_fetch)
    );

    nlink_conflict #(.N(NP)) clash_i (
        .my_wr (wr_left),
        .my_rd (rd_req),
        .nb_wr (nb_wr_req_i),
        .nb_rd (nb_rd_req_i),
        .clash (deadlock_o)
    );

    always_comb begin
        word = '0;
        for (int k = 0; k < NP; k++) begin
            if (grant[k]) word = word | nb_wdata_i[k*W +: W];
        end
    end

    assign stall_o       = stall;
    assign link_rd_req_o = rd_req;
    assign link_wr_req_o = wr_left;
    assign link_wdata_o  = (op_i == OP_WRITE) ? wdata_i : '0;
    assign link_take_o   = grant;
    assign link_give_o   = give;
    assign rd_valid_o    = readish && done && !is_fetch;
    assign ins_valid_o   = readish && done && is_fetch;
    assign rdata_o       = rd_valid_o ? word : '0;
    assign ins_word_o    = ins_valid_o ? word : '0;
endmodule

// File: rtl/nlink_port_chk.sv
module nlink_port_chk #(
    parameter int NP = 4,
    parameter int W  = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    op_i,
    input logic [NP-1:0] mask_i,
    input logic          stall_o,
    input logic          rd_valid_o,
    input logic          ins_valid_o,
    input logic [NP-1:0] link_take_o,
    input logic [NP-1:0] link_give_o,
    input logic [NP-1:0] link_wr_req_o,
    input logic [NP-1:0] nb_rd_req_i,
    input logic [NP-1:0] nb_wr_req_i,
    input logic          deadlock_o
);
    AST_TAKE_HAS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        (link_take_o & ~(nb_wr_req_i & mask_i)) == '0); // R1
    AST_GIVE_HAS_READER: assert property (@(posedge clk) disable iff (!rst_n)
        (link_give_o & ~nb_rd_req_i) == '0); // R2
    AST_WR_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd2 && stall_o) |=> (op_i != 2'd2) || ((link_give_o & $past(link_give_o)) == '0)); // R3
    AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_take_o)); // R4
    AST_TAKE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_take_o - 1'b1) & link_take_o) == '0 &&
        ((({NP{1'b0}} | (link_take_o - 1'b1)) & nb_wr_req_i & mask_i & {NP{link_take_o != '0}}) == '0)); // R4
    AST_FETCH_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_o |-> (!rd_valid_o && op_i == 2'd3)); // R5
    AST_CLASH_HOLDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (deadlock_o && op_i == 2'd2) |-> stall_o); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd0) |-> (!stall_o && link_wr_req_o == '0 && !rd_valid_o)); // R7
endmodule

bind nlink_port nlink_port_chk #(.NP(NP), .W(W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_i          (op_i),
    .mask_i        (mask_i),
    .stall_o       (stall_o),
    .rd_valid_o    (rd_valid_o),
    .ins_valid_o   (ins_valid_o),
    .link_take_o   (link_take_o),
    .link_give_o   (link_give_o),
    .link_wr_req_o (link_wr_req_o),
    .nb_rd_req_i   (nb_rd_req_i),
    .nb_wr_req_i   (nb_wr_req_i),
    .deadlock_o    (deadlock_o)
);

// File: tb/nlink_port_tb.sv
module nlink_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_i;
    logic [3:0]  mask_i;
    logic [17:0] wdata_i;
    logic        stall_o, rd_valid_o, ins_valid_o, deadlock_o;
    logic [17:0] rdata_o, ins_word_o, link_wdata_o;
    logic [3:0]  link_rd_req_o, link_wr_req_o, link_take_o, link_give_o;
    logic [3:0]  nb_rd_req_i, nb_wr_req_i;
    logic [71:0] nb_wdata_i;

    int total = 0;
    int bad = 0;
    logic [3:0] served = '0;

    always #2 clk = ~clk;

    nlink_port dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .mask_i(mask_i), .wdata_i(wdata_i),
        .stall_o(stall_o), .rdata_o(rdata_o), .rd_valid_o(rd_valid_o),
        .ins_word_o(ins_word_o), .ins_valid_o(ins_valid_o),
        .link_rd_req_o(link_rd_req_o), .link_wr_req_o(link_wr_req_o),
        .link_wdata_o(link_wdata_o), .link_take_o(link_take_o), .link_give_o(link_give_o),
        .nb_rd_req_i(nb_rd_req_i), .nb_wr_req_i(nb_wr_req_i), .nb_wdata_i(nb_wdata_i),
        .deadlock_o(deadlock_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] lowest(input logic [3:0] v);
        return v & (~v + 4'd1);
    endfunction

    // compare all outputs to the requirement model, then advance served model at the edge
    task automatic check_cycle();
        logic [3:0]  left, give, take, rdm;
        logic        rdl, done, stl, dl;
        logic [17:0] word;
        rdl  = (op_i == 2'd1) || (op_i == 2'd3);
        left = (op_i == 2'd2) ? (mask_i & ~served) : 4'd0;
        give = left & nb_rd_req_i;
        take = rdl ? lowest(mask_i & nb_wr_req_i) : 4'd0;
        rdm  = rdl ? mask_i : 4'd0;
        done = (op_i == 2'd2) ? ((left & ~give) == 4'd0) : (take != 4'd0);
        stl  = (op_i != 2'd0) && !done;
        dl   = |((left & nb_wr_req_i) | (rdm & nb_rd_req_i));
        word = '0;
        for (int k = 0; k < 4; k++) if (take[k]) word = nb_wdata_i[k*18 +: 18];
        chk("R1 stall", {31'd0, stall_o}, {31'd0, stl});
        chk("R1 rd_req", {28'd0, link_rd_req_o}, {28'd0, rdm});
        chk("R1 rd_valid", {31'd0, rd_valid_o}, {31'd0, (op_i == 2'd1) && done});
        chk("R1 rdata", {14'd0, rdata_o}, {14'd0, (op_i == 2'd1 && done) ? word : 18'd0});
        chk("R2 give", {28'd0, link_give_o}, {28'd0, give});
        chk("R3 wr_req", {28'd0, link_wr_req_o}, {28'd0, left});
        chk("R4 take", {28'd0, link_take_o}, {28'd0, take});
        chk("R5 ins_valid", {31'd0, ins_valid_o}, {31'd0, (op_i == 2'd3) && done});
        chk("R5 ins_word", {14'd0, ins_word_o}, {14'd0, (op_i == 2'd3 && done) ? word : 18'd0});
        chk("R6 deadlock", {31'd0, deadlock_o}, {31'd0, dl});
        if (op_i == 2'd2 && stl) served = served | give;
        else served = '0;
    endtask

    task automatic step();
        #2;
        check_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic set_nb(input logic [3:0] rd, input logic [3:0] wr);
        nb_rd_req_i = rd;
        nb_wr_req_i = wr;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        op_i = 2'd0; mask_i = 4'd0; wdata_i = '0;
        set_nb(4'd0, 4'd0);
        for (int k = 0; k < 4; k++) nb_wdata_i[k*18 +: 18] = 18'(32'h100 * (k + 1) + k);
        repeat (3) @(posedge clk);
        #1;
        // R7: reset state with no access
        chk("R7 stall", {31'd0, stall_o}, 32'd0);
        chk("R7 deadlock", {31'd0, deadlock_o}, 32'd0);
        chk("R7 links", {16'd0, link_rd_req_o, link_wr_req_o, link_take_o, link_give_o}, 32'd0);
        chk("R7 valids", {30'd0, rd_valid_o, ins_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R3: write to N,S,W served one link per cycle
        op_i = 2'd2; mask_i = 4'b1101; wdata_i = 18'h2a5a5;
        set_nb(4'b0000, 4'd0); step();
        set_nb(4'b0100, 4'd0); step();
        set_nb(4'b0101, 4'd0); step();   // south served again: no repeat give
        chk("R3 still stalled", {31'd0, stall_o}, 32'd1);
        set_nb(4'b1000, 4'd0); step();
        op_i = 2'd0; set_nb(4'd0, 4'd0); step();

        // R6: both ends write east, then resolve
        op_i = 2'd2; mask_i = 4'b0010; wdata_i = 18'h11111;
        set_nb(4'd0, 4'b0010); step();
        chk("R6 flag", {31'd0, deadlock_o}, 32'd1);
        set_nb(4'b0010, 4'd0); step();
        op_i = 2'd0; set_nb(4'd0, 4'd0); step();

        // R4: read with writers on all links picks north; then E/W picks east
        op_i = 2'd1; mask_i = 4'b1111;
        set_nb(4'd0, 4'b1111); step();
        op_i = 2'd1; mask_i = 4'b1010;
        set_nb(4'd0, 4'b1111); step();
        // R5: fetch from west
        op_i = 2'd3; mask_i = 4'b1000;
        set_nb(4'd0, 4'b0000); step();
        set_nb(4'd0, 4'b1000); step();
        // R6: read conflict on south
        op_i = 2'd1; mask_i = 4'b0100;
        set_nb(4'b0100, 4'd0); step();
        set_nb(4'b0000, 4'b0100); step();
        op_i = 2'd0; set_nb(4'd0, 4'd0); step();

        // constrained random: R1..R6
        for (int n = 0; n < 3000; n++) begin
            if (!stall_o) begin
                op_i    = 2'($urandom_range(0, 3));
                mask_i  = 4'($urandom_range(1, 15));
                wdata_i = 18'($urandom);
            end
            for (int k = 0; k < 4; k++) begin
                int pick;
                pick = $urandom_range(0, 2);
                nb_rd_req_i[k] = (pick == 1);
                nb_wr_req_i[k] = (pick == 2);
                nb_wdata_i[k*18 +: 18] = 18'($urandom);
            end
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule